// File: doc/BRIEF.md
# Shadow-Buffered PWM Timer

This block is a period timer with one rate comparator and several duty comparators. Each comparator has two copies of its value. Software writes a staging copy. The comparator only ever sees a shadow copy. Values move from staging to shadow at a period boundary. Because several channels can move in the same clock edge, a period and a set of duties can be changed together without a glitched period in between.

The transfer rule depends on the mode bit. With the mode bit clear, every counter restart copies all staging values into the shadows. A restart is either a period match or the hold bit. With the mode bit set, only channels whose latch-enable bit is set are copied, and only on a period match. A copied channel's latch-enable bit then clears by itself. The period shadow must therefore be loaded, with the mode bit clear, before the mode bit is set.

Register writes use a single-cycle strobe (`wr_en` with address and data) that is always accepted. There is no valid/ready handshake at the edge and no back-pressure, since nothing in the block can stall. `wr_data` is as wide as the counter, and the number of channels plus one must not exceed that width.

Top module: `pwm_shadow_timer`

## Requirements
- R1: A write to a staging register (address 0 = period, address k = duty channel k, for 1 ≤ k ≤ N_DUTY) does not change `count` behaviour or `pwm_out` until that value reaches the shadow.
- R2: With the mode bit set, a shadow is loaded only on a period match, and only when its latch-enable bit is set. All flagged channels load on the same edge.
- R3: A write to address N_DUTY+1 sets a latch-enable bit wherever a data bit is 1. Bit 0 is the period and bit k is duty channel k. Zero bits have no effect. In mode 1, every set bit clears on the period match that consumes it.
- R4: With the mode bit clear, every shadow loads from staging on each counter restart, that is, on a period match or while the hold bit is 1. Latch-enable bits play no part in this.
- R5: Control register at address N_DUTY+2: bit0 run, bit1 hold, bit2 mode. While running and not held, `count` increments each cycle. When `count` equals a nonzero period shadow, the next value is 1 in mode 1 and 0 in mode 0.
- R6: While the hold bit is 1, `count` is forced to the start value, which is 1 in mode 1 and 0 in mode 0.
- R7: With a period shadow of 0 there is never a period match. In mode 1, no shadow transfer can then ever happen.
- R8: `pwm_out[k-1]` is 1 exactly while `count` is below shadow k. A shadow of 0 keeps the output low, and a shadow above the period shadow keeps it high.
- R9: If a staging write and that channel's transfer fall on the same edge, the shadow takes the newly written value.
- R10: After reset, `count` is 0, all registers are 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | $clog2(N_DUTY+3) | Register address |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Current counter value |
| pwm_out | output | N_DUTY | One output per duty channel |

## Verification
The bench sweeps the period and every duty value from 0 to above the period. It checks each cycle against an arithmetic model of the requirements. A design that compared staging instead of shadow values would switch duty in mid-period. A design that ignored latch-enable in mode 1 would change the channels before the flags were written, and one that failed to clear the flags would keep taking later writes.

The bench also issues a write on the exact edge of a period match. Old staging data appearing on the output then exposes a design that loses the same-cycle write. A final run leaves the period shadow at 0 in mode 1. A design that let the counter overflow count as a match would wrongly start transferring values.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam int CTL_RUN  = 0;
  localparam int CTL_HOLD = 1;
  localparam int CTL_MODE = 2;
  localparam int CTL_W    = 3;

  typedef struct packed {
    logic mode;
    logic hold;
    logic run;
  } ctl_t;
endpackage

// File: rtl/pst_counter.sv
module pst_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic             mode,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             restart
);
  logic [CNT_W-1:0] start_val;

  assign start_val = {{(CNT_W-1){1'b0}}, mode};
  assign wrap      = run && !hold && (period != '0) && (cnt == period);
  assign restart   = wrap || hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (hold) begin
      cnt <= start_val;
    end else if (run) begin
      if (wrap) cnt <= start_val;
      else      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pst_match_bank.sv
module pst_match_bank #(
  parameter int CNT_W   = 8,
  parameter int N_MATCH = 4,
  parameter int ADDR_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [CNT_W-1:0]           wr_data,
  input  logic [N_MATCH-1:0]         le_set,
  input  logic                       mode,
  input  logic                       wrap,
  input  logic                       restart,
  output logic [N_MATCH*CNT_W-1:0]   sh_flat,
  output logic [N_MATCH-1:0]         le_q
);
  logic [N_MATCH-1:0] xfer;

  for (genvar i = 0; i < N_MATCH; i++) begin : g_ch
    logic [CNT_W-1:0] stage_q;
    logic [CNT_W-1:0] stage_n;
    logic [CNT_W-1:0] shadow_q;

    assign stage_n = (wr_en && (wr_addr == ADDR_W'(i))) ? wr_data : stage_q;
    assign xfer[i] = mode ? (wrap && le_q[i]) : restart;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q  <= '0;
        shadow_q <= '0;
      end else begin
        stage_q <= stage_n;
        if (xfer[i]) shadow_q <= stage_n;
      end
    end

    assign sh_flat[i*CNT_W +: CNT_W] = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) le_q <= '0;
    else        le_q <= (le_q & ~((mode && wrap) ? le_q : '0)) | le_set;
  end
endmodule

// File: rtl/pst_pwm_out.sv
module pst_pwm_out #(
  parameter int CNT_W  = 8,
  parameter int N_DUTY = 3
) (
  input  logic [CNT_W-1:0]            cnt,
  input  logic [(N_DUTY+1)*CNT_W-1:0] sh_flat,
  output logic [N_DUTY-1:0]           pwm_out
);
  for (genvar j = 0; j < N_DUTY; j++) begin : g_out
    assign pwm_out[j] = cnt < sh_flat[(j+1)*CNT_W +: CNT_W];
  end
endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer #(
  parameter int CNT_W  = 8,
  parameter int N_DUTY = 3,
  localparam int N_MATCH = N_DUTY + 1,
  localparam int ADDR_W  = $clog2(N_DUTY + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count,
  output logic [N_DUTY-1:0] pwm_out
);
  import pst_pkg::*;

  localparam logic [ADDR_W-1:0] ADDR_LE  = ADDR_W'(N_DUTY + 1);
  localparam logic [ADDR_W-1:0] ADDR_CTL = ADDR_W'(N_DUTY + 2);

  ctl_t                     ctl_q;
  logic                     wrap;
  logic                     restart;
  logic [N_MATCH*CNT_W-1:0] sh_flat;
  logic [N_MATCH-1:0]       le_q;
  logic [N_MATCH-1:0]       le_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ctl_q <= '0;
    else if (wr_en && (wr_addr == ADDR_CTL)) ctl_q <= ctl_t'(wr_data[CTL_W-1:0]);
  end

  assign le_set = (wr_en && (wr_addr == ADDR_LE)) ? wr_data[N_MATCH-1:0] : '0;

  pst_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctl_q.run),
    .hold    (ctl_q.hold),
    .mode    (ctl_q.mode),
    .period  (sh_flat[CNT_W-1:0]),
    .cnt     (count),
    .wrap    (wrap),
    .restart (restart)
  );

  pst_match_bank #(.CNT_W(CNT_W), .N_MATCH(N_MATCH), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .le_set  (le_set),
    .mode    (ctl_q.mode),
    .wrap    (wrap),
    .restart (restart),
    .sh_flat (sh_flat),
    .le_q    (le_q)
  );

  pst_pwm_out #(.CNT_W(CNT_W), .N_DUTY(N_DUTY)) u_out (
    .cnt     (count),
    .sh_flat (sh_flat),
    .pwm_out (pwm_out)
  );
endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
  parameter int CNT_W  = 8,
  parameter int N_DUTY = 3,
  parameter int ADDR_W = 3
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            wr_en,
  input logic [ADDR_W-1:0]               wr_addr,
  input logic [2:0]                      ctl,
  input logic [CNT_W-1:0]                cnt,
  input logic                            wrap,
  input logic                            restart,
  input logic [(N_DUTY+1)*CNT_W-1:0]     sh_flat,
  input logic [N_DUTY:0]                 le_q,
  input logic [N_DUTY-1:0]               pwm_out
);
  logic le_wr;
  assign le_wr = wr_en && (wr_addr == ADDR_W'(N_DUTY + 1));

  // R2: in mode 1 the shadows move only on a period match
  a_r2_gated_by_match: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[2] && !wrap) |=> $stable(sh_flat));

  // R4: in mode 0 the shadows move only on a counter restart
  a_r4_only_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[2] && !restart) |=> $stable(sh_flat));

  a_r3_le_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[2] && wrap && !le_wr) |=> (le_q == '0));

  a_r3_zero_bits_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (le_wr && !(ctl[2] && wrap)) |=> ((le_q & $past(le_q)) == $past(le_q)));

  a_r5_restart_value: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == CNT_W'($past(ctl[2]))));

  a_r5_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[0] && !ctl[1] && !wrap) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r6_hold_start: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[1] |=> (cnt == CNT_W'($past(ctl[2]))));

  a_r7_no_match_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_flat[CNT_W-1:0] == '0) |-> !wrap);

  for (genvar j = 0; j < N_DUTY; j++) begin : g_chk
    a_r8_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_flat[(j+1)*CNT_W +: CNT_W] == '0) |-> !pwm_out[j]);
  end
endmodule

bind pwm_shadow_timer pst_checker #(.CNT_W(CNT_W), .N_DUTY(N_DUTY), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .ctl     (ctl_q),
  .cnt     (count),
  .wrap    (wrap),
  .restart (restart),
  .sh_flat (sh_flat),
  .le_q    (le_q),
  .pwm_out (pwm_out)
);

// File: tb/pwm_shadow_timer_bench.sv
module pwm_shadow_timer_bench;
  localparam int CW    = 8;
  localparam int ND    = 3;
  localparam int NM    = ND + 1;
  localparam int AW    = $clog2(ND + 3);
  localparam int A_LE  = ND + 1;
  localparam int A_CTL = ND + 2;
  localparam int MAXC  = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] count;
  logic [ND-1:0] pwm_out;

  always #10 clk = ~clk;

  pwm_shadow_timer #(.CNT_W(CW), .N_DUTY(ND)) u_pwm_shadow_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .pwm_out(pwm_out)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  int m_cnt;
  int m_sh[NM];
  int m_mr[NM];
  logic [NM-1:0] m_le;
  bit m_run, m_hold, m_mode;

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_pwm();
    int r = 0;
    for (int j = 0; j < ND; j++)
      if (m_cnt < m_sh[j+1]) r |= (1 << j);
    return r;
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_le = '0; m_run = 0; m_hold = 0; m_mode = 0;
    for (int i = 0; i < NM; i++) begin m_sh[i] = 0; m_mr[i] = 0; end
  endtask

  // check the current cycle, then advance the requirement model by one edge
  task automatic tick();
    int  mr_n[NM];
    int  a, d, st;
    bit  wrp, rst;
    chk("R5/R6/R7 count", int'(count), m_cnt);
    chk("R1/R2/R4/R8/R9 output", int'(pwm_out), exp_pwm());
    a = int'(wr_addr); d = int'(wr_data);
    for (int i = 0; i < NM; i++) mr_n[i] = m_mr[i];
    if (wr_en && a < NM) mr_n[a] = d;
    st  = m_mode ? 1 : 0;
    wrp = m_run && !m_hold && (m_sh[0] != 0) && (m_cnt == m_sh[0]);
    rst = wrp || m_hold;
    for (int i = 0; i < NM; i++)
      if (m_mode ? (wrp && m_le[i]) : rst) m_sh[i] = mr_n[i];
    if (m_mode && wrp) m_le = '0;
    if (wr_en && a == A_LE) m_le |= d[NM-1:0];
    if (m_hold) m_cnt = st;
    else if (m_run) m_cnt = wrp ? st : (m_cnt + 1) % MAXC;
    for (int i = 0; i < NM; i++) m_mr[i] = mr_n[i];
    if (wr_en && a == A_CTL) begin
      m_run = d[0]; m_hold = d[1]; m_mode = d[2];
    end
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic run_to(int c);
    for (int k = 0; k < 600 && m_cnt != c; k++) tick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();

    // R10: reset state
    chk("R10 count after reset", int'(count), 0);
    chk("R10 outputs low", int'(pwm_out), 0);
    ticks(3);

    // R5/R8 sweep of periods in mode 0
    for (int p = 3; p <= 8; p++) begin
      wr(0, p); wr(1, 0); wr(2, p / 2); wr(3, p + 1);
      wr(A_CTL, 2); wr(A_CTL, 1);
      ticks(2 * (p + 1));
      run_to(p);
      chk("R8 duty above period held high", int'(pwm_out[2]), 1);
      chk("R8 zero duty held low", int'(pwm_out[0]), 0);
    end

    // R1/R4 duty sweep with period 5, written while running
    wr(0, 5); wr(A_CTL, 2); wr(A_CTL, 1);
    for (int d = 0; d <= 7; d++) begin
      run_to(2);
      wr(1, d);
      run_to(0);
      chk("R4 new duty after counter restart", int'(pwm_out[0]), (d > 0) ? 1 : 0);
      ticks(7);
    end

    // R6: hold keeps the counter at start
    wr(A_CTL, 3);
    ticks(4);
    chk("R6 held at start value", int'(count), 0);
    wr(A_CTL, 1);

    // clean shadows 1,2,3 in mode 0, then switch to mode 1
    wr(1, 1); wr(2, 2); wr(3, 3);
    run_to(5); tick();
    wr(A_CTL, 5);
    wr(1, 4); wr(2, 5);
    ticks(15);
    run_to(1);
    chk("R2 no transfer without latch-enable", int'(pwm_out), 6);
    wr(A_LE, 6);
    run_to(5); tick();
    chk("R2 flagged channels switch together", int'(pwm_out), 7);
    run_to(3);
    chk("R2 channel 3 unflagged keeps old duty", int'(pwm_out), 3);

    // R3: zeros do nothing, bits are consumed
    wr(A_LE, 0);
    wr(1, 2);
    ticks(6);
    run_to(2);
    chk("R3 latch-enable cleared after use", int'(pwm_out), 7);

    // R9: staging write on the same edge as the transfer
    wr(A_LE, 2);
    run_to(5);
    wr(1, 1);
    chk("R9 same-cycle write wins", int'(pwm_out[0]), 0);
    wr(0, 7); wr(A_LE, 1);
    ticks(20);

    // R7: period never loaded before mode 1
    do_reset();
    wr(A_CTL, 5);
    wr(0, 10); wr(1, 3); wr(A_LE, 15);
    ticks(600);
    chk("R7 no transfer with zero period", int'(pwm_out), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule